// File: doc/BRIEF.md
# Packet-Loaded Playback Byte Buffer

This block is a byte-wide playback store for test patterns. Software-side logic fills it by sending a series of fixed-size packets. Each packet picks up at the address where the previous one stopped, because the write pointer is not rewound between packets. A separate consumer then pulls the stored bytes out in order, one per read strobe. The read data comes back one clock after the strobe, with the timing of a synchronous block RAM.

The write side and the read side each keep their own pointer, and each pointer has its own clear strobe. A replay can therefore be restarted from the first byte without touching what was loaded. A new load can start from address zero without moving the replay position. Writes that arrive while the store is full are discarded and raise a sticky overflow flag. Reads that reach the loaded length return zero and raise a sticky underflow flag.

Capacity and packet size are parameters, and both must be powers of two. The production setting is 16384 bytes loaded in 2048-byte packets, which takes 8 loads. A 512-byte packet variant takes 32 loads. The default elaboration uses a reduced 2048-byte store with 256-byte packets, which keeps the same ratio of 8 packets per fill.

Top module: `pb_playback_buf`

## Requirements
- R1: While `rst` is high, and on the first edge after it, the block shows `wr_level`=0, `rd_pos`=0, `pkts_loaded`=0, and `full`, `overflow`, `underflow`, `rd_valid` and `pkt_done` all low.
- R2: A write (`wr_en` high, `wr_clr` low, not full) stores `wr_data` at address `wr_level` and raises `wr_level` by one. Successive packets continue at the next address with no rewind between packets.
- R3: `pkt_done` is high for exactly the one cycle after a write whose new `wr_level` is a nonzero multiple of `PKT_BYTES`. `pkts_loaded` always equals `wr_level / PKT_BYTES`.
- R4: `full` is high exactly when `wr_level` equals `DEPTH`. A write while full is dropped, leaves `wr_level` unchanged and sets `overflow`, which then stays high until `wr_clr`.
- R5: A read (`rd_en` high, `rd_clr` low) with `rd_pos` < `wr_level` gives, one cycle later, `rd_valid`=1 and `rd_data` equal to the byte stored at `rd_pos`, and `rd_pos` advances by one.
- R6: A read with `rd_pos` >= `wr_level` gives, one cycle later, `rd_valid`=1 and `rd_data`=0. It leaves `rd_pos` unchanged and sets `underflow`, which then stays high until `rd_clr`.
- R7: `rd_clr` sets `rd_pos` to 0 and clears `underflow`. A read strobed in the same cycle is not performed (`rd_valid` low next cycle). Stored bytes and `wr_level` are kept.
- R8: `wr_clr` sets `wr_level` to 0 and clears `overflow`. A write strobed in the same cycle is dropped. `rd_pos` is kept.
- R9: When a read and a write occur in the same cycle, the read is judged against `wr_level` as it stood before that write. With `rd_pos` equal to `wr_level`, the read underflows and the write is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_clr | input | 1 | Rewind write pointer to 0, clear overflow |
| rd_clr | input | 1 | Rewind read pointer to 0, clear underflow |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Read strobe for one byte |
| rd_data | output | 8 | Byte read, valid one cycle after the strobe |
| rd_valid | output | 1 | A read was answered this cycle |
| wr_level | output | log2(DEPTH)+1 | Bytes loaded so far |
| rd_pos | output | log2(DEPTH)+1 | Next replay address |
| pkts_loaded | output | log2(DEPTH)+1-log2(PKT_BYTES) | Complete packets loaded |
| full | output | 1 | Store is at capacity |
| pkt_done | output | 1 | One-cycle pulse after a packet boundary write |
| overflow | output | 1 | Sticky: a write hit a full store |
| underflow | output | 1 | Sticky: a read passed the loaded length |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a clear strobe together with the access on the same side. The second pair is a read together with a write when the read pointer sits exactly at the write pointer. The bench drives `wr_clr` together with `wr_en`, and `rd_clr` together with `rd_en`, and expects the clear to win: the level or position is zero, the flag is low and the access is absent. It then rewinds both pointers to zero and strobes a read and a write in one cycle. It expects a zero underflow answer at that moment and the newly written byte on the next read.

// File: rtl/pb_pkg.sv
package pb_pkg;

    typedef logic [7:0] byte_t;

    // Outcome of a read, held for the cycle in which the answer is shown
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_HIT  = 2'd1,
        RD_MISS = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic  en;
        byte_t data;
    } wr_beat_t;

    // Pointer width able to hold the value "depth" itself
    function automatic int unsigned ptr_bits(input int unsigned depth);
        return $clog2(depth) + 1;
    endfunction

endpackage

// File: rtl/pb_ram.sv
module pb_ram
    import pb_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output byte_t         q
);

    byte_t store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
        if (re) begin
            q <= store[raddr];
        end
    end

endmodule

// File: rtl/pb_wr_ctrl.sv
module pb_wr_ctrl
    import pb_pkg::*;
#(
    parameter int unsigned DEPTH     = 2048,
    parameter int unsigned PKT_BYTES = 256,
    localparam int unsigned AW       = $clog2(DEPTH),
    localparam int unsigned PW       = ptr_bits(DEPTH),
    localparam int unsigned PB       = $clog2(PKT_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  wr_beat_t      beat,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output byte_t         mem_wdata,
    output logic [PW-1:0] level,
    output logic          full,
    output logic          overflow,
    output logic          pkt_done
);

    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    logic [PW-1:0] level_q;
    logic [PW-1:0] level_inc;
    logic          ovf_q;
    logic          done_q;
    logic          accept;
    logic          at_boundary;

    assign full        = (level_q == CAP);
    assign accept      = beat.en && !clr && !full;
    assign level_inc   = level_q + PW'(1);
    assign at_boundary = (level_inc[PB-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '0;
            ovf_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (clr) begin
                level_q <= '0;
                ovf_q   <= 1'b0;
            end else if (beat.en) begin
                if (full) begin
                    ovf_q <= 1'b1;
                end else begin
                    level_q <= level_inc;
                    done_q  <= at_boundary;
                end
            end
        end
    end

    assign mem_we    = accept;
    assign mem_waddr = level_q[AW-1:0];
    assign mem_wdata = beat.data;
    assign level     = level_q;
    assign overflow  = ovf_q;
    assign pkt_done  = done_q;

endmodule

// File: rtl/pb_rd_ctrl.sv
module pb_rd_ctrl
    import pb_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned PW   = ptr_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          rd_en,
    input  logic [PW-1:0] wr_level,
    output logic          mem_re,
    output logic [AW-1:0] mem_raddr,
    output logic [PW-1:0] pos,
    output logic          underflow,
    output rd_kind_e      kind
);

    logic [PW-1:0] pos_q;
    logic          unf_q;
    rd_kind_e      kind_q;
    logic          avail;

    // compared against the level before any same-cycle write
    assign avail = (pos_q < wr_level);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            unf_q  <= 1'b0;
            kind_q <= RD_NONE;
        end else begin
            kind_q <= RD_NONE;
            if (clr) begin
                pos_q <= '0;
                unf_q <= 1'b0;
            end else if (rd_en) begin
                if (avail) begin
                    pos_q  <= pos_q + PW'(1);
                    kind_q <= RD_HIT;
                end else begin
                    unf_q  <= 1'b1;
                    kind_q <= RD_MISS;
                end
            end
        end
    end

    assign mem_re    = rd_en && !clr && avail;
    assign mem_raddr = pos_q[AW-1:0];
    assign pos       = pos_q;
    assign underflow = unf_q;
    assign kind      = kind_q;

endmodule

// File: rtl/pb_playback_buf.sv
module pb_playback_buf
    import pb_pkg::*;
#(
    parameter int unsigned DEPTH     = 2048,
    parameter int unsigned PKT_BYTES = 256,
    localparam int unsigned PW       = ptr_bits(DEPTH),
    localparam int unsigned PB       = $clog2(PKT_BYTES),
    localparam int unsigned AW       = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_clr,
    input  logic          rd_clr,
    input  logic          wr_en,
    input  logic [7:0]    wr_data,
    input  logic          rd_en,
    output logic [7:0]    rd_data,
    output logic          rd_valid,
    output logic [PW-1:0] wr_level,
    output logic [PW-1:0] rd_pos,
    output logic [PW-PB-1:0] pkts_loaded,
    output logic          full,
    output logic          pkt_done,
    output logic          overflow,
    output logic          underflow
);

    wr_beat_t      beat;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    byte_t         mem_wdata;
    logic          mem_re;
    logic [AW-1:0] mem_raddr;
    byte_t         mem_q;
    rd_kind_e      kind;

    assign beat.en   = wr_en;
    assign beat.data = wr_data;

    pb_wr_ctrl #(
        .DEPTH     (DEPTH),
        .PKT_BYTES (PKT_BYTES)
    ) u_wr (
        .clk       (clk),
        .rst       (rst),
        .clr       (wr_clr),
        .beat      (beat),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .level     (wr_level),
        .full      (full),
        .overflow  (overflow),
        .pkt_done  (pkt_done)
    );

    pb_rd_ctrl #(
        .DEPTH (DEPTH)
    ) u_rd (
        .clk       (clk),
        .rst       (rst),
        .clr       (rd_clr),
        .rd_en     (rd_en),
        .wr_level  (wr_level),
        .mem_re    (mem_re),
        .mem_raddr (mem_raddr),
        .pos       (rd_pos),
        .underflow (underflow),
        .kind      (kind)
    );

    pb_ram #(
        .DEPTH (DEPTH)
    ) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (mem_raddr),
        .q     (mem_q)
    );

    assign rd_valid    = (kind != RD_NONE);
    assign rd_data     = (kind == RD_HIT) ? mem_q : '0;
    assign pkts_loaded = wr_level[PW-1:PB];

endmodule

// File: rtl/pb_playback_chk.sv
module pb_playback_chk
    import pb_pkg::*;
#(
    parameter int unsigned DEPTH     = 2048,
    parameter int unsigned PKT_BYTES = 256,
    localparam int unsigned PW       = ptr_bits(DEPTH),
    localparam int unsigned PB       = $clog2(PKT_BYTES)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_clr,
    input logic          rd_clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic [7:0]    rd_data,
    input logic          rd_valid,
    input logic [PW-1:0] wr_level,
    input logic [PW-1:0] rd_pos,
    input logic          full,
    input logic          pkt_done,
    input logic          overflow,
    input logic          underflow
);

    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (wr_level == '0 && rd_pos == '0 && !overflow && !underflow
                 && !rd_valid && !pkt_done));

    // R2
    level_step_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_clr |=> (wr_level == $past(wr_level) || wr_level == $past(wr_level) + PW'(1)));

    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wr_level <= CAP);

    // R3
    pkt_edge_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_done |-> (wr_level != '0 && wr_level[PB-1:0] == '0));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !wr_clr) |=> (wr_level == $past(wr_level) && overflow));

    // R4
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (overflow && !wr_clr) |=> overflow);

    // R5
    rd_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_clr && rd_pos < wr_level) |=> (rd_valid && rd_pos == $past(rd_pos) + PW'(1)));

    // R6
    rd_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !rd_clr && rd_pos >= wr_level) |=> (rd_valid && rd_data == 8'h00
                                                     && underflow && $stable(rd_pos)));

    // R7
    rd_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        rd_clr |=> (rd_pos == '0 && !underflow && !rd_valid));

    // R8
    wr_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> (wr_level == '0 && !overflow && !pkt_done));

endmodule

bind pb_playback_buf pb_playback_chk #(
    .DEPTH     (DEPTH),
    .PKT_BYTES (PKT_BYTES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_clr    (wr_clr),
    .rd_clr    (rd_clr),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .wr_level  (wr_level),
    .rd_pos    (rd_pos),
    .full      (full),
    .pkt_done  (pkt_done),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/tb_pb_playback_buf.sv
`timescale 1ns/1ps
module tb_pb_playback_buf;

    localparam int DEPTH = 2048;
    localparam int PKT   = 256;
    localparam int PW    = $clog2(DEPTH) + 1;
    localparam int PB    = $clog2(PKT);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_clr = 1'b0;
    logic rd_clr = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic rd_valid;
    logic [PW-1:0] wr_level;
    logic [PW-1:0] rd_pos;
    logic [PW-PB-1:0] pkts_loaded;
    logic full, pkt_done, overflow, underflow;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    logic [7:0] model [DEPTH];
    int mlev = 0;
    int mpos = 0;

    always #2 clk = ~clk;

    pb_playback_buf #(.DEPTH(DEPTH), .PKT_BYTES(PKT)) dut (
        .clk(clk), .rst(rst), .wr_clr(wr_clr), .rd_clr(rd_clr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_valid(rd_valid), .wr_level(wr_level),
        .rd_pos(rd_pos), .pkts_loaded(pkts_loaded), .full(full),
        .pkt_done(pkt_done), .overflow(overflow), .underflow(underflow)
    );

    function automatic logic [7:0] pat(input int i, input int seed);
        return 8'((i * 37) + (i >> 8) * 11 + seed);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stream n bytes; counts pkt_done pulses and checks each against the model
    task automatic load_bytes(input int n, input int seed, output int pulses);
        pulses = 0;
        for (int k = 0; k < n; k++) begin
            wr_en   = 1'b1;
            wr_data = pat(mlev, seed);
            @(negedge clk);
            if (mlev < DEPTH) begin
                model[mlev] = pat(mlev, seed);
                mlev++;
                if (pkt_done) pulses++;
                // R3 pulse exactly when the new level is a packet multiple
                if ((mlev % PKT == 0) != pkt_done)
                    check(1'b0, "R3 pkt_done timing", int'(pkt_done), int'(mlev % PKT == 0));
            end
        end
        wr_en = 1'b0;
    endtask

    task automatic read_bytes(input int n, input string req);
        int errs = 0;
        for (int k = 0; k < n; k++) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            if (!rd_valid || rd_data != model[mpos]) begin
                errs++;
                if (errs == 1) check(1'b0, req, int'(rd_data), int'(model[mpos]));
            end
            mpos++;
        end
        check(errs == 0, req, errs, 0);
        check(rd_pos == PW'(mpos), req, int'(rd_pos), mpos);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1 held in reset
        check(wr_level == 0 && rd_pos == 0 && pkts_loaded == 0, "R1 pointers", int'(wr_level), 0);
        check(!full && !overflow && !underflow && !rd_valid && !pkt_done, "R1 flags",
              int'({full, overflow, underflow, rd_valid, pkt_done}), 0);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_load_three();
        int p;
        load_bytes(3 * PKT, 5, p);
        // R2 packets continue without rewind; R3 count
        check(wr_level == PW'(3 * PKT), "R2 level after 3 packets", int'(wr_level), 3 * PKT);
        check(p == 3, "R3 pulses for 3 packets", p, 3);
        check(pkts_loaded == 3, "R3 pkts_loaded", int'(pkts_loaded), 3);
    endtask

    task automatic t_replay_and_underflow();
        read_bytes(300, "R5 partial replay");
        read_bytes(3 * PKT - 300, "R5 rest of replay");
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        // R6 read at the loaded length
        check(rd_valid && rd_data == 8'h00, "R6 zero answer", int'(rd_data), 0);
        check(underflow, "R6 underflow set", int'(underflow), 1);
        check(rd_pos == PW'(mpos), "R6 rd_pos held", int'(rd_pos), mpos);
        @(negedge clk);
        check(underflow, "R6 underflow sticky", int'(underflow), 1);
    endtask

    task automatic t_read_rewind();
        rd_clr = 1'b1;
        rd_en  = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        rd_en  = 1'b0;
        mpos = 0;
        // R7 clear wins over read in the same cycle
        check(!rd_valid, "R7 read suppressed", int'(rd_valid), 0);
        check(rd_pos == 0 && !underflow, "R7 rewind", int'(rd_pos), 0);
        check(wr_level == PW'(mlev), "R7 level kept", int'(wr_level), mlev);
        read_bytes(5, "R7 data kept after rewind");
    endtask

    task automatic t_fill_overflow();
        int p;
        load_bytes(DEPTH - mlev, 5, p);
        check(p == DEPTH / PKT - 3, "R3 pulses to fill", p, DEPTH / PKT - 3);
        // R4 full at capacity
        check(full && wr_level == PW'(DEPTH), "R4 full", int'(wr_level), DEPTH);
        check(!overflow, "R4 no overflow yet", int'(overflow), 0);
        load_bytes(3, 99, p);
        check(wr_level == PW'(DEPTH) && p == 0, "R4 writes dropped", int'(wr_level), DEPTH);
        check(overflow, "R4 overflow set", int'(overflow), 1);
        check(pkts_loaded == PW'(DEPTH / PKT), "R3 pkts_loaded full", int'(pkts_loaded), DEPTH / PKT);
        read_bytes(5, "R4 stored data intact");
    endtask

    task automatic t_write_rewind();
        int keep = mpos;
        wr_clr  = 1'b1;
        wr_en   = 1'b1;
        wr_data = 8'h3C;
        @(negedge clk);
        wr_clr = 1'b0;
        wr_en  = 1'b0;
        mlev = 0;
        // R8 clear wins, write dropped, read position kept
        check(wr_level == 0 && !full && !pkt_done, "R8 level rewound", int'(wr_level), 0);
        check(!overflow, "R8 overflow cleared", int'(overflow), 0);
        check(rd_pos == PW'(keep), "R8 rd_pos kept", int'(rd_pos), keep);
    endtask

    task automatic t_collide();
        rd_clr = 1'b1;
        @(negedge clk);
        rd_clr = 1'b0;
        mpos = 0;
        rd_en   = 1'b1;
        wr_en   = 1'b1;
        wr_data = 8'hA5;
        @(negedge clk);
        rd_en = 1'b0;
        wr_en = 1'b0;
        model[0] = 8'hA5;
        mlev = 1;
        // R9 read judged on level before the write
        check(rd_valid && rd_data == 8'h00 && underflow, "R9 read underflows", int'(rd_data), 0);
        check(wr_level == 1 && rd_pos == 0, "R9 write stored", int'(wr_level), 1);
        read_bytes(1, "R9 new byte replayed");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_load_three();
        t_replay_and_underflow();
        t_read_rewind();
        t_fill_overflow();
        t_write_rewind();
        t_collide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule